// File: doc/BRIEF.md
# Multi-UART Global Register and Interrupt Hub

This block is the memory-mapped front end of a bridge that carries several serial channels. A simple 32-bit register bus with a single-cycle request strobe reaches it, and it splits the 16 KiB aperture into two kinds of window. The low 4 KiB hold a small set of global registers. Above that, each configured UART owns a fixed 512-byte window whose lower half is passed to that UART's register port. The upper half is a dead DMA area.

The hub samples each UART's interrupt request level into a global status word. It keeps an interrupt enable mask and a separate wake enable mask. Each mask has its own write-one-to-set address and its own write-one-to-clear address, and the clear address reads back the inverse of the mask. One level-sensitive interrupt output is raised while any status bit also has its enable bit set. Software reads the status word to find which channel needs service, and uses the set and clear addresses to change the masks without a read-modify-write.

Top module: `serhub_top`

## Requirements
- R1: A read of offset 0x000 returns 0x00070002. A read of offset 0x004 returns the UART count parameter `UART_CNT`, which is 1 to 16.
- R2: A read of offset 0x008 returns the status word. Bit i of that word equals `uartIrq[i]` as sampled at the previous clock edge, and bits at or above `UART_CNT` read 0.
- R3: A write to 0x00C ORs write-data bits [UART_CNT-1:0] into the interrupt enable mask, and higher write-data bits are dropped. A read of 0x00C returns the mask, zero-extended to 32 bits.
- R4: A write to 0x010 clears each enable bit whose write-data bit is 1. A read of 0x010 returns the bitwise inverse of the zero-extended mask.
- R5: After every clock edge, `irqOut` is 1 exactly when the status word ANDed with the enable mask is nonzero.
- R6: Offsets 0x014 (set, reads the mask) and 0x018 (clear, reads the inverse) work the same way on a separate wake enable mask. That mask never changes `irqOut`.
- R7: An offset A of 0x1000 or more selects UART index (A-0x1000)>>9 with register offset (A-0x1000)&0x1FF. When the index is below `UART_CNT` and the register offset is below 0x100, `uartSel` is one-hot on that index during the request cycle, with `uartWe`=`busWe`, `uartRegAddr`=A[7:0] and `uartWdata`=`busWdata`. A read returns word i of `uartRdata` (bits 32i+31..32i).
- R8: UART register offsets 0x100 to 0x1FF raise no `uartSel`. Reads there return 0 and writes change nothing.
- R9: Reads of undefined global offsets, and of UART indices at or above `UART_CNT`, return 0. Writes to those addresses, and to 0x000, 0x004 or 0x008, change no state.
- R10: `busReady` is 1 in the cycle after each request cycle and only then. `busRdata` carries the read value in that cycle and is 0 otherwise, and also 0 after a write.
- R11: While `rstN` is 0, the status word and both masks are cleared, and `irqOut` and `busReady` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Single-cycle access request |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset within the 16 KiB aperture |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Access completion, one cycle after busReq |
| irqOut | output | 1 | Level interrupt to the host |
| uartIrq | input | UART_CNT | Per-UART interrupt request levels |
| uartSel | output | UART_CNT | One-hot register-port select, request cycle |
| uartWe | output | 1 | Forwarded write flag |
| uartRegAddr | output | 8 | Forwarded register offset |
| uartWdata | output | 32 | Forwarded write data |
| uartRdata | input | UART_CNT*32 | Packed per-UART read data |

## Verification
The hardest case is the interrupt output while the status word and the enable mask both change. A UART level may toggle in the same cycle as a set or clear write, and a stale term in either would show only then. The stimulus raises and drops request levels next to enable writes, clears, and wake-mask writes that must leave the output alone. A behavioural model predicts the output on every clock, so a one-cycle error is caught wherever it occurs. The decode boundaries are reached by sweeping every UART window, the first out-of-range index, the top of the aperture and the DMA half of a live window.

// File: rtl/serhub_pkg.sv
package serhub_pkg;
  localparam logic [31:0] ID_WORD   = 32'h0007_0002;
  localparam int          GLOB_TOP  = 'h1000;
  localparam int          WIN_SHIFT = 9;

  localparam logic [11:0] OFS_ID       = 12'h000;
  localparam logic [11:0] OFS_COUNT    = 12'h004;
  localparam logic [11:0] OFS_STATUS   = 12'h008;
  localparam logic [11:0] OFS_EN_SET   = 12'h00C;
  localparam logic [11:0] OFS_EN_CLR   = 12'h010;
  localparam logic [11:0] OFS_WAKE_SET = 12'h014;
  localparam logic [11:0] OFS_WAKE_CLR = 12'h018;

  typedef enum logic [3:0] {
    RS_ZERO, RS_ID, RS_COUNT, RS_STATUS, RS_EN, RS_EN_INV,
    RS_WAKE, RS_WAKE_INV, RS_UART
  } rdSel_e;

  typedef struct packed {
    logic   rd;
    logic   enSet;
    logic   enClr;
    logic   wakeSet;
    logic   wakeClr;
    rdSel_e rdSel;
  } hubStrobe_t;
endpackage

// File: rtl/serhub_ctrl.sv
module serhub_ctrl
  import serhub_pkg::*;
#(
  parameter int UART_CNT = 6,
  parameter int ADDR_W   = 14,
  localparam int IDX_W   = ADDR_W - WIN_SHIFT
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReq,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  output hubStrobe_t          stb,
  output logic [IDX_W-1:0]    uartIdx,
  output logic [UART_CNT-1:0] uartSel
);
  logic              globalWin;
  logic [ADDR_W-1:0] winOff;
  logic              uartHit;
  logic              fwdHit;
  logic              dmaHit;
  logic              wr;

  assign globalWin = busAddr < ADDR_W'(GLOB_TOP);
  assign winOff    = busAddr - ADDR_W'(GLOB_TOP);
  assign uartIdx   = winOff[ADDR_W-1:WIN_SHIFT];
  assign uartHit   = !globalWin && (int'(uartIdx) < UART_CNT);
  assign fwdHit    = uartHit && !winOff[WIN_SHIFT-1];
  assign dmaHit    = uartHit && winOff[WIN_SHIFT-1];
  assign wr        = busReq && busWe;

  always_comb begin
    stb       = '0;
    stb.rdSel = RS_ZERO;
    stb.rd    = busReq && !busWe;
    if (globalWin) begin
      case (busAddr[11:0])
        OFS_ID:       stb.rdSel = RS_ID;
        OFS_COUNT:    stb.rdSel = RS_COUNT;
        OFS_STATUS:   stb.rdSel = RS_STATUS;
        OFS_EN_SET:   begin stb.rdSel = RS_EN;       stb.enSet   = wr; end
        OFS_EN_CLR:   begin stb.rdSel = RS_EN_INV;   stb.enClr   = wr; end
        OFS_WAKE_SET: begin stb.rdSel = RS_WAKE;     stb.wakeSet = wr; end
        OFS_WAKE_CLR: begin stb.rdSel = RS_WAKE_INV; stb.wakeClr = wr; end
        default:      stb.rdSel = RS_ZERO;
      endcase
    end else if (fwdHit) begin
      stb.rdSel = RS_UART;
    end
  end

  for (genvar g = 0; g < UART_CNT; g++) begin : g_sel
    assign uartSel[g] = busReq && fwdHit && (uartIdx == IDX_W'(g));
  end

  p_dma_dead_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && dmaHit) |-> (uartSel == '0));

  p_global_no_fwd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && globalWin) |-> (uartSel == '0));
endmodule

// File: rtl/serhub_datapath.sv
module serhub_datapath
  import serhub_pkg::*;
#(
  parameter int UART_CNT = 6,
  parameter int IDX_W    = 5,
  localparam int PAD_W   = 32 - UART_CNT
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  hubStrobe_t             stb,
  input  logic                   busReq,
  input  logic [IDX_W-1:0]       uartIdx,
  input  logic [UART_CNT-1:0]    wrMask,
  input  logic [UART_CNT-1:0]    uartIrq,
  input  logic [UART_CNT*32-1:0] uartRdata,
  output logic [31:0]            busRdata,
  output logic                   busReady,
  output logic                   irqOut
);
  logic [UART_CNT-1:0] status;
  logic [UART_CNT-1:0] irqEn;
  logic [UART_CNT-1:0] wakeEn;
  logic [31:0]         uartWord [UART_CNT];
  logic [31:0]         rdNext;

  for (genvar g = 0; g < UART_CNT; g++) begin : g_word
    assign uartWord[g] = uartRdata[g*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      irqEn  <= '0;
      wakeEn <= '0;
    end else begin
      status <= uartIrq;
      if (stb.enSet)        irqEn  <= irqEn | wrMask;
      else if (stb.enClr)   irqEn  <= irqEn & ~wrMask;
      if (stb.wakeSet)      wakeEn <= wakeEn | wrMask;
      else if (stb.wakeClr) wakeEn <= wakeEn & ~wrMask;
    end
  end

  always_comb begin
    rdNext = '0;
    case (stb.rdSel)
      RS_ID:       rdNext = ID_WORD;
      RS_COUNT:    rdNext = 32'(UART_CNT);
      RS_STATUS:   rdNext = {{PAD_W{1'b0}}, status};
      RS_EN:       rdNext = {{PAD_W{1'b0}}, irqEn};
      RS_EN_INV:   rdNext = ~{{PAD_W{1'b0}}, irqEn};
      RS_WAKE:     rdNext = {{PAD_W{1'b0}}, wakeEn};
      RS_WAKE_INV: rdNext = ~{{PAD_W{1'b0}}, wakeEn};
      RS_UART: begin
        for (int i = 0; i < UART_CNT; i++)
          if (uartIdx == IDX_W'(i)) rdNext = uartWord[i];
      end
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      busReady <= 1'b0;
    end else begin
      busReady <= busReq;
      busRdata <= stb.rd ? rdNext : '0;
    end
  end

  assign irqOut = |(status & irqEn);

  p_en_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.enSet |=> ((irqEn & $past(wrMask)) == $past(wrMask)));

  p_en_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.enClr |=> ((irqEn & $past(wrMask)) == '0));

  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn == '0) |-> !irqOut);
endmodule

// File: rtl/serhub_top.sv
module serhub_top
  import serhub_pkg::*;
#(
  parameter int UART_CNT = 6,
  parameter int ADDR_W   = 14,
  localparam int IDX_W   = ADDR_W - WIN_SHIFT
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busReq,
  input  logic                   busWe,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  output logic                   busReady,
  output logic                   irqOut,
  input  logic [UART_CNT-1:0]    uartIrq,
  output logic [UART_CNT-1:0]    uartSel,
  output logic                   uartWe,
  output logic [7:0]             uartRegAddr,
  output logic [31:0]            uartWdata,
  input  logic [UART_CNT*32-1:0] uartRdata
);
  hubStrobe_t       stb;
  logic [IDX_W-1:0] uartIdx;

  serhub_ctrl #(.UART_CNT(UART_CNT), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .stb(stb), .uartIdx(uartIdx), .uartSel(uartSel)
  );

  serhub_datapath #(.UART_CNT(UART_CNT), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busReq(busReq), .uartIdx(uartIdx),
    .wrMask(busWdata[UART_CNT-1:0]), .uartIrq(uartIrq),
    .uartRdata(uartRdata), .busRdata(busRdata), .busReady(busReady),
    .irqOut(irqOut)
  );

  assign uartWe      = busWe;
  assign uartRegAddr = busAddr[7:0];
  assign uartWdata   = busWdata;

  p_ready_follows_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> busReady);

  p_ready_has_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> $past(busReq));
endmodule

// File: tb/serhub_top_tb_top.sv
module serhub_top_tb_top;
  localparam int UART_CNT = 6;
  localparam int ADDR_W   = 14;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   busReq = 1'b0;
  logic                   busWe = 1'b0;
  logic [ADDR_W-1:0]      busAddr = '0;
  logic [31:0]            busWdata = '0;
  logic [31:0]            busRdata;
  logic                   busReady;
  logic                   irqOut;
  logic [UART_CNT-1:0]    uartIrq = '0;
  logic [UART_CNT-1:0]    uartSel;
  logic                   uartWe;
  logic [7:0]             uartRegAddr;
  logic [31:0]            uartWdata;
  logic [UART_CNT*32-1:0] uartRdata;

  always #10 clk = ~clk;

  serhub_top #(.UART_CNT(UART_CNT), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .irqOut(irqOut), .uartIrq(uartIrq), .uartSel(uartSel), .uartWe(uartWe),
    .uartRegAddr(uartRegAddr), .uartWdata(uartWdata), .uartRdata(uartRdata)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  // behavioural model state
  int unsigned mStatus = 0, mEn = 0, mWake = 0;
  int unsigned maskAll = (1 << UART_CNT) - 1;

  function automatic int unsigned uartWordOf(int i);
    return 32'hC0DE_0000 | (i << 8) | 32'h5A;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(int unsigned a, bit we);
    int unsigned off, idx;
    if (a < 'h1000) begin
      if (we && (a == 0 || a == 4 || a == 8)) return "R9";
      case (a)
        0, 4: return "R1";
        8: return "R2";
        'hC: return "R3";
        'h10: return "R4";
        'h14, 'h18: return "R6";
        default: return "R9";
      endcase
    end
    off = a - 'h1000; idx = off >> 9;
    if (idx >= UART_CNT) return "R9";
    if ((off & 'h1FF) >= 'h100) return "R8";
    return "R7";
  endfunction

  function automatic int unsigned modelRead(int unsigned a);
    int unsigned off, idx;
    if (a < 'h1000) begin
      case (a)
        0: return 32'h0007_0002;
        4: return UART_CNT;
        8: return mStatus;
        'hC: return mEn;
        'h10: return ~mEn;
        'h14: return mWake;
        'h18: return ~mWake;
        default: return 0;
      endcase
    end
    off = a - 'h1000; idx = off >> 9;
    if (idx >= UART_CNT || (off & 'h1FF) >= 'h100) return 0;
    return uartWordOf(idx);
  endfunction

  function automatic int unsigned modelSel(int unsigned a);
    int unsigned off, idx;
    if (a < 'h1000) return 0;
    off = a - 'h1000; idx = off >> 9;
    if (idx >= UART_CNT || (off & 'h1FF) >= 'h100) return 0;
    return 1 << idx;
  endfunction

  // one clock: drive at negedge, compare at the following negedge
  task automatic cycle(bit req, bit we, int unsigned a, int unsigned wd,
                       logic [UART_CNT-1:0] irqV);
    int unsigned expRd;
    string tg;
    busReq = req; busWe = we; busAddr = ADDR_W'(a); busWdata = wd; uartIrq = irqV;
    tg = tagOf(a, we);
    #1;
    if (req) begin
      check(tg, 32'(uartSel), modelSel(a));
      if (modelSel(a) != 0) begin
        check("R7", 32'({uartWe, uartRegAddr}), 32'({we, 8'(a)}));
        check("R7", uartWdata, wd);
      end
    end
    expRd = (req && !we) ? modelRead(a) : 0;
    @(posedge clk);
    mStatus = 32'(irqV);
    if (req && we && a == 'hC)  mEn   = mEn | (wd & maskAll);
    if (req && we && a == 'h10) mEn   = mEn & ~wd;
    if (req && we && a == 'h14) mWake = mWake | (wd & maskAll);
    if (req && we && a == 'h18) mWake = mWake & ~wd;
    @(negedge clk);
    check("R10", 32'(busReady), 32'(req));
    check(tg, busRdata, expRd);
    check("R5", 32'(irqOut), 32'((mStatus & mEn) != 0));
  endtask

  task automatic rd(int unsigned a); cycle(1, 0, a, 0, uartIrq); endtask
  task automatic wr(int unsigned a, int unsigned d); cycle(1, 1, a, d, uartIrq); endtask
  task automatic idle(logic [UART_CNT-1:0] v); cycle(0, 0, 0, 0, v); endtask

  task automatic doReset();
    busReq = 0; uartIrq = '0; rstN = 0;
    repeat (2) @(negedge clk);
    mStatus = 0; mEn = 0; mWake = 0;
    check("R11", 32'({busReady, irqOut}), 0);
    rstN = 1;
  endtask

  initial begin
    for (int i = 0; i < UART_CNT; i++) uartRdata[i*32 +: 32] = uartWordOf(i);
    @(negedge clk);
    doReset();
    rd('h8); rd('h0); rd('h4);
    // R2 status sampling
    idle(6'b000101); rd('h8);
    // R3/R5 enable set with bits above count dropped
    wr('hC, 32'hFFFF_0001); rd('hC); rd('h10);
    // R6 wake mask does not disturb the interrupt
    wr('h14, 32'h3F); rd('h14); rd('h18); wr('h18, 32'h1); rd('h14);
    // R4 clear, then enable a quiet channel and raise it
    wr('h10, 32'h1); rd('h10);
    wr('hC, 32'h2); idle(6'b000010); idle(6'b000000);
    // status change concurrent with enable writes
    cycle(1, 1, 'hC, 32'h20, 6'b100000);
    cycle(1, 1, 'h10, 32'h20, 6'b100010);
    cycle(1, 1, 'h18, 32'h3F, 6'b000000);
    // R9 read-only and undefined addresses
    wr('h8, 32'hFFFF); wr('h0, 0); wr('h4, 0); wr('h1C, 32'hFFFF);
    rd('h0); rd('h4); rd('h8); rd('hC); rd('h1C); rd('hFFC);
    // R7 forwarding over every window
    for (int i = 0; i < UART_CNT; i++) rd('h1000 + i * 'h200 + 'h10);
    wr('h1000 + 3 * 'h200 + 'h04, 32'hDEAD_BEEF);
    rd('h1000 + 5 * 'h200 + 'hFC);
    // R8 DMA half
    rd('h1000 + 2 * 'h200 + 'h100); wr('h1000 + 1 * 'h200 + 'h1F0, 32'h1);
    // R9 beyond the count
    rd('h1000 + UART_CNT * 'h200); wr('h1000 + UART_CNT * 'h200, 32'h1);
    rd('h3FFC);
    // R11 reset mid-run
    wr('hC, 32'h3F); wr('h14, 32'h3F); idle(6'b111111);
    doReset();
    rd('hC); rd('h14); rd('h8);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule